// File: doc/BRIEF.md
# Lane-Wise Dot Product with Scalar Accumulate

This block takes two 128-bit vectors, splits them into lanes, multiplies each pair of matching lanes and adds all the products to a 32-bit scalar accumulator. The output is one 32-bit scalar. Every operation carries its own lane layout and data type. The layout is 16 lanes of 8 bits, 8 lanes of 16 bits or 4 lanes of 32 bits, and the lanes are read as signed or unsigned. Each operation can therefore be set up differently from the one before it.

The datapath has three registered stages: lane multiply, product summation and accumulate. It accepts a new operation on every cycle in which the input strobe is high. There is no back-pressure. Each result comes out with a one-cycle valid strobe a fixed three cycles after its operation was taken. All arithmetic wraps modulo 2^32.

Top module: `lane_dot_acc`

## Requirements
- R1: When lane_sel is 2'b00, the vectors are 16 lanes of 8 bits, with lane i at bits [8i+7:8i]. The result is acc_in plus the sum of vec_a lane i times vec_b lane i.
- R2: When lane_sel is 2'b01, the vectors are 8 lanes of 16 bits, with lane i at bits [16i+15:16i]. Summation is the same as in R1.
- R3: When lane_sel is 2'b10 or 2'b11, the vectors are 4 lanes of 32 bits, with lane i at bits [32i+31:32i]. Both codes behave identically.
- R4: When is_signed is 1, each lane is a two's-complement value and is sign-extended before it is multiplied. When is_signed is 0, each lane is zero-extended.
- R5: The result is the exact sum reduced modulo 2^32. There is no saturation or clamping when it overflows.
- R6: An operation sampled with in_valid high produces out_valid high, together with its result, exactly 3 clock edges later. Operations on consecutive cycles, each with its own lane_sel and is_signed, give consecutive results in order.
- R7: While in_valid is low, the data inputs are ignored: out_valid stays low and result keeps the last value it produced.
- R8: During and after reset, before any operation, out_valid is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe; the inputs are sampled when it is high |
| vec_a | input | 128 | First lane vector |
| vec_b | input | 128 | Second lane vector |
| acc_in | input | 32 | Scalar accumulator added to the lane sum |
| lane_sel | input | 2 | Lane width code: 00 = 8-bit, 01 = 16-bit, 10 or 11 = 32-bit |
| is_signed | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| out_valid | output | 1 | High for one cycle when result is new |
| result | output | 32 | Wrapped sum of the lane products plus the accumulator |

## Verification
The bench builds the block with its default 128-bit vector width, which gives 16, 8 and 4 lanes. Every lane-width code, including the duplicate 32-bit code, can then be reached with a full set of lanes, together with both signedness settings. At this width the all-ones 32-bit lane products overflow the 32-bit result many times over, and the 16-lane 8-bit mode puts the most terms into the sum. Back-to-back operations with mixed settings exercise the per-stage capture of each operation's settings.

// File: rtl/lane_dot_pkg.sv
package lane_dot_pkg;

  localparam int unsigned LDOT_ACC_W = 32;

  typedef enum logic [1:0] {
    LW_8   = 2'b00,
    LW_16  = 2'b01,
    LW_32  = 2'b10,
    LW_32X = 2'b11
  } lane_width_e;

  // Extend a lane of width w to 33 bits (sign or zero), multiply, keep the low word.
  function automatic logic [LDOT_ACC_W-1:0] ext_mul(
    input logic [LDOT_ACC_W-1:0] a,
    input logic [LDOT_ACC_W-1:0] b,
    input int                    w,
    input logic                  sgn
  );
    logic [LDOT_ACC_W:0]       ea;
    logic [LDOT_ACC_W:0]       eb;
    logic [2*LDOT_ACC_W+1:0]   p;
    for (int i = 0; i <= LDOT_ACC_W; i++) begin
      if (i < w) begin
        ea[i] = a[i];
        eb[i] = b[i];
      end else begin
        ea[i] = sgn & a[w-1];
        eb[i] = sgn & b[w-1];
      end
    end
    p = $signed(ea) * $signed(eb);
    return p[LDOT_ACC_W-1:0];
  endfunction

  function automatic logic [LDOT_ACC_W-1:0] wrap_add(
    input logic [LDOT_ACC_W-1:0] x,
    input logic [LDOT_ACC_W-1:0] y
  );
    return x + y;
  endfunction

endpackage

// File: rtl/ldot_mul_stage.sv
module ldot_mul_stage
  import lane_dot_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic [VEC_W-1:0]                    vec_a,
  input  logic [VEC_W-1:0]                    vec_b,
  input  logic [LDOT_ACC_W-1:0]               acc_in,
  input  logic [1:0]                          lane_sel,
  input  logic                                is_signed,
  output logic                                v1,
  output logic [VEC_W/8-1:0][LDOT_ACC_W-1:0]  terms1,
  output logic [LDOT_ACC_W-1:0]               acc1,
  output logic [1:0]                          sel1
);
  localparam int unsigned N8  = VEC_W / 8;
  localparam int unsigned N16 = VEC_W / 16;
  localparam int unsigned N32 = VEC_W / 32;

  logic [N8-1:0][LDOT_ACC_W-1:0]  p8;
  logic [N16-1:0][LDOT_ACC_W-1:0] p16;
  logic [N32-1:0][LDOT_ACC_W-1:0] p32;
  logic [N8-1:0][LDOT_ACC_W-1:0]  nxt;

  for (genvar g = 0; g < N8; g++) begin : g_l8
    assign p8[g] = ext_mul({24'd0, vec_a[g*8 +: 8]}, {24'd0, vec_b[g*8 +: 8]}, 8, is_signed);
  end
  for (genvar g = 0; g < N16; g++) begin : g_l16
    assign p16[g] = ext_mul({16'd0, vec_a[g*16 +: 16]}, {16'd0, vec_b[g*16 +: 16]}, 16, is_signed);
  end
  for (genvar g = 0; g < N32; g++) begin : g_l32
    assign p32[g] = ext_mul(vec_a[g*32 +: 32], vec_b[g*32 +: 32], 32, is_signed);
  end

  // Each summation slot takes the product of the selected lane width; slots past the lane count are zero.
  for (genvar s = 0; s < N8; s++) begin : g_slot
    logic [LDOT_ACC_W-1:0] t16;
    logic [LDOT_ACC_W-1:0] t32;
    if (s < N16) begin : g_h16
      assign t16 = p16[s];
    end else begin : g_n16
      assign t16 = '0;
    end
    if (s < N32) begin : g_h32
      assign t32 = p32[s];
    end else begin : g_n32
      assign t32 = '0;
    end
    assign nxt[s] = (lane_sel == LW_8)  ? p8[s] :
                    (lane_sel == LW_16) ? t16   : t32;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      terms1 <= '0;
      acc1   <= '0;
      sel1   <= LW_8;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        terms1 <= nxt;
        acc1   <= acc_in;
        sel1   <= lane_sel;
      end
    end
  end

endmodule

// File: rtl/ldot_tree_stage.sv
module ldot_tree_stage
  import lane_dot_pkg::*;
#(
  parameter int unsigned TERMS = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              v1,
  input  logic [TERMS-1:0][LDOT_ACC_W-1:0]  terms1,
  input  logic [LDOT_ACC_W-1:0]             acc1,
  output logic                              v2,
  output logic [LDOT_ACC_W-1:0]             sum2,
  output logic [LDOT_ACC_W-1:0]             acc2
);
  logic [LDOT_ACC_W-1:0] total;

  always_comb begin
    total = '0;
    for (int i = 0; i < TERMS; i++) begin
      total = wrap_add(total, terms1[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      sum2 <= '0;
      acc2 <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        sum2 <= total;
        acc2 <= acc1;
      end
    end
  end

endmodule

// File: rtl/ldot_acc_stage.sv
module ldot_acc_stage
  import lane_dot_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  v2,
  input  logic [LDOT_ACC_W-1:0] sum2,
  input  logic [LDOT_ACC_W-1:0] acc2,
  output logic                  out_valid,
  output logic [LDOT_ACC_W-1:0] result
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= v2;
      if (v2) begin
        result <= wrap_add(sum2, acc2);
      end
    end
  end

endmodule

// File: rtl/lane_dot_acc.sv
module lane_dot_acc
  import lane_dot_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [VEC_W-1:0]      vec_a,
  input  logic [VEC_W-1:0]      vec_b,
  input  logic [LDOT_ACC_W-1:0] acc_in,
  input  logic [1:0]            lane_sel,
  input  logic                  is_signed,
  output logic                  out_valid,
  output logic [LDOT_ACC_W-1:0] result
);
  localparam int unsigned TERMS = VEC_W / 8;

  // Stage events brought out for the checker
  logic                             v1;
  logic                             v2;
  logic [TERMS-1:0][LDOT_ACC_W-1:0] terms1;
  logic [LDOT_ACC_W-1:0]            acc1;
  logic [1:0]                       sel1;
  logic [LDOT_ACC_W-1:0]            sum2;
  logic [LDOT_ACC_W-1:0]            acc2;

  ldot_mul_stage #(.VEC_W(VEC_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .vec_a(vec_a), .vec_b(vec_b), .acc_in(acc_in),
    .lane_sel(lane_sel), .is_signed(is_signed),
    .v1(v1), .terms1(terms1), .acc1(acc1), .sel1(sel1)
  );

  ldot_tree_stage #(.TERMS(TERMS)) u_tree (
    .clk(clk), .rst_n(rst_n), .v1(v1), .terms1(terms1), .acc1(acc1),
    .v2(v2), .sum2(sum2), .acc2(acc2)
  );

  ldot_acc_stage u_acc (
    .clk(clk), .rst_n(rst_n), .v2(v2), .sum2(sum2), .acc2(acc2),
    .out_valid(out_valid), .result(result)
  );

endmodule

// File: rtl/ldot_checks.sv
module ldot_checks #(
  parameter int unsigned TERMS = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     v1,
  input logic                     v2,
  input logic                     out_valid,
  input logic [31:0]              result,
  input logic [1:0]               sel1,
  input logic [TERMS-1:0][31:0]   terms1
);
  logic hi16_nz;
  logic hi32_nz;

  always_comb begin
    hi16_nz = 1'b0;
    hi32_nz = 1'b0;
    for (int s = 0; s < TERMS; s++) begin
      if (s >= TERMS/2 && terms1[s] != '0) hi16_nz = 1'b1;
      if (s >= TERMS/4 && terms1[s] != '0) hi32_nz = 1'b1;
    end
  end

  // R6: strobe travels through each stage one edge at a time
  p_stage1_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> v1);
  p_stage2_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> v2);
  p_out_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |=> out_valid);
  p_no_stray_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> !out_valid);
  // R7: result only moves on an output strobe
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));
  // R2: 16-bit layout leaves the upper half of the slots empty
  p_unused_slots_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && sel1 == 2'b01) |-> !hi16_nz);
  // R3: 32-bit layout leaves three quarters of the slots empty
  p_unused_slots_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && sel1[1]) |-> !hi32_nz);

endmodule

bind lane_dot_acc ldot_checks #(.TERMS(VEC_W/8)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .v1(v1), .v2(v2),
  .out_valid(out_valid), .result(result), .sel1(sel1), .terms1(terms1)
);

// File: tb/lane_dot_acc_bench.sv
module lane_dot_acc_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] vec_a = '0;
  logic [127:0] vec_b = '0;
  logic [31:0]  acc_in = '0;
  logic [1:0]   lane_sel = 2'b00;
  logic         is_signed = 1'b0;
  logic         out_valid;
  logic [31:0]  result;

  typedef struct {
    logic [31:0] exp;
    int          req;
    int          due;
  } sb_item_t;

  sb_item_t    sb[$];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  int          n_stray = 0;
  logic [31:0] last_res = '0;
  bit          done = 1'b0;

  lane_dot_acc u_lane_dot_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_a(vec_a), .vec_b(vec_b),
    .acc_in(acc_in), .lane_sel(lane_sel), .is_signed(is_signed),
    .out_valid(out_valid), .result(result)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input int rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  // Independent reference: lane extraction with shifts and masks, 64-bit wrap arithmetic.
  function automatic logic [31:0] model(input logic [127:0] a, input logic [127:0] b,
                                        input logic [31:0] acc, input logic [1:0] sel,
                                        input logic sg);
    int          w = (sel == 2'b00) ? 8 : (sel == 2'b01) ? 16 : 32;
    logic [63:0] mask = (64'd1 << w) - 64'd1;
    logic [63:0] s = {32'd0, acc};
    for (int ln = 0; ln < 128 / w; ln++) begin
      logic [63:0] x = 64'(a >> (ln * w)) & mask;
      logic [63:0] y = 64'(b >> (ln * w)) & mask;
      if (sg && x[w-1]) x = x | ~mask;
      if (sg && y[w-1]) y = y | ~mask;
      s = s + x * y;
    end
    return s[31:0];
  endfunction

  task automatic send(input logic [127:0] a, input logic [127:0] b, input logic [31:0] acc,
                      input logic [1:0] sel, input logic sg, input int rq);
    sb_item_t it;
    @(negedge clk);
    in_valid  = 1'b1;
    vec_a     = a;
    vec_b     = b;
    acc_in    = acc;
    lane_sel  = sel;
    is_signed = sg;
    it.exp = model(a, b, acc, sel, sg);
    it.req = rq;
    it.due = cyc + 3;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      vec_a     = {$urandom, $urandom, $urandom, $urandom};
      vec_b     = {$urandom, $urandom, $urandom, $urandom};
      acc_in    = $urandom;
      lane_sel  = 2'($urandom);
      is_signed = 1'($urandom);
    end
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        n_stray++;
      end else begin
        sb_item_t it;
        it = sb.pop_front();
        check(result == it.exp, it.req, result, it.exp);
        check(cyc == it.due, 6, 32'(cyc), 32'(it.due)); // R6 latency
        last_res = result;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, 8, 32'(out_valid), 32'd0); // R8 in reset
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, 8, 32'(out_valid), 32'd0); // R8 after reset
    check(result == 32'd0, 8, result, 32'd0);           // R8

    // R1: 8-bit unsigned, small ascending lanes
    send({16{8'd3}}, 128'h0f0e0d0c0b0a09080706050403020100, 32'd7, 2'b00, 1'b0, 1);
    // R4: 8-bit signed vs unsigned on the same data
    send({16{8'hff}}, {16{8'h02}}, 32'd100, 2'b00, 1'b1, 4);
    send({16{8'hff}}, {16{8'h02}}, 32'd100, 2'b00, 1'b0, 4);
    // R2: 16-bit lanes, unsigned then signed
    send(128'h0008000700060005000400030002_0001, {8{16'd1000}}, 32'd5, 2'b01, 1'b0, 2);
    send({8{16'h8000}}, {8{16'h0002}}, 32'd0, 2'b01, 1'b1, 4);
    // R3: 32-bit lanes with both codes
    send({32'd4, 32'd3, 32'd2, 32'd1}, {4{32'd10}}, 32'd1, 2'b10, 1'b0, 3);
    send({32'd4, 32'd3, 32'd2, 32'd1}, {4{32'd10}}, 32'd1, 2'b11, 1'b0, 3);
    send({4{32'hffffffff}}, {4{32'd3}}, 32'd20, 2'b11, 1'b1, 3);
    // R5: overflow wraps
    send({4{32'hffffffff}}, {4{32'hffffffff}}, 32'hffffffff, 2'b10, 1'b0, 5);
    send({16{8'hff}}, {16{8'hff}}, 32'hfffff000, 2'b00, 1'b0, 5);
    idle(6);
    // R7: inputs ignored while strobe is low
    check(result == last_res, 7, result, last_res);
    check(sb.size() == 0, 7, 32'(sb.size()), 32'd0);

    // R6: back-to-back mixed operations
    for (int k = 0; k < 300; k++) begin
      logic [1:0] sl = 2'($urandom);
      send({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
           $urandom, sl, 1'($urandom), (sl == 2'b00) ? 1 : (sl == 2'b01) ? 2 : 3);
      if (k % 37 == 36) idle(2);
    end
    idle(8);
    check(sb.size() == 0, 6, 32'(sb.size()), 32'd0);
    check(n_stray == 0, 7, 32'(n_stray), 32'd0); // R7 no output without an operation
    finish_run();
  end

endmodule